// File: doc/BRIEF.md
# Framebuffer Band Dirty Tracker

This block records which horizontal bands of a framebuffer have been written since they were last refreshed. It then turns that record into a short list of full-width rectangles for a display refresh engine. One band is four scanlines. The framebuffer has three planes: an 8-bit index plane with 1024-byte lines, a 24-bit colour plane and a control plane. The last two use four bytes per pixel, so one band covers a region four times larger in those planes. A snoop port sees every write address together with the plane it targets, and it marks the band it falls in. An invalidate input marks every band at once.

A one-cycle start pulse begins a scan. The scan visits the bands in ascending order, one band per clock. Each run of consecutive dirty bands is merged into one rectangle, given as a start row and a height in rows. Rectangles leave on a valid/ready handshake. The walk stalls for as long as the consumer holds ready low. The scan clears each band it finds dirty at the moment it visits that band. A write that arrives in that same cycle or later sets the band again, so it is kept for the next scan. When the scan finishes, a one-cycle done pulse follows.

Top module: `fb_band_dirty_tracker`

## Requirements
- R1: After reset, no band is dirty. A scan started with no writes emits no rectangle, `rect_valid` and `scan_busy` are low, and `scan_done` pulses.
- R2: A write to plane code 0 marks band `addr / 4096`. An isolated dirty band b yields a rectangle with `rect_row` = 4*b and `rect_height` = 4.
- R3: Writes to plane codes 1 (24-bit) and 2 (control) mark band `addr / 16384`. Writes with plane code 3, and writes whose band index is at or above NUM_BANDS, are ignored.
- R4: Consecutive dirty bands f..l merge into one rectangle with row 4*f and height 4*(l-f+1). Separate runs give separate rectangles in ascending row order.
- R5: A run that reaches the last band is emitted as a final rectangle before the scan ends.
- R6: A scan clears every band it found dirty. A second scan with no new writes emits nothing.
- R7: A write to a band after the scan has visited it survives, and the next scan reports it.
- R8: A pulse on `invalidate` marks all bands. The next scan emits one rectangle with row 0 and height 4*NUM_BANDS (768 by default).
- R9: While `rect_valid` is high and `rect_ready` is low, the rectangle stays valid and unchanged, and the walk does not advance.
- R10: `scan_busy` is high from the cycle after an accepted start until the scan ends. `scan_done` is high for exactly one cycle, with `scan_busy` low. A start pulse during a scan is ignored.
- R11: `rect_width` always equals the active width parameter (1024 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| snoop_valid | input | 1 | A framebuffer write is seen this cycle |
| snoop_plane | input | 2 | Plane of the write: 0 index, 1 colour, 2 control, 3 none |
| snoop_addr | input | ADDR_W (22) | Byte address within the plane |
| invalidate | input | 1 | Mark every band dirty |
| scan_start | input | 1 | Start a scan (ignored while busy) |
| scan_busy | output | 1 | A scan is in progress |
| scan_done | output | 1 | One-cycle pulse when a scan ends |
| rect_valid | output | 1 | A rectangle is offered |
| rect_ready | input | 1 | The consumer accepts the rectangle |
| rect_row | output | ROW_W (10) | First scanline of the rectangle |
| rect_height | output | ROW_W (10) | Number of scanlines in the rectangle |
| rect_width | output | WID_W (11) | Active width of every rectangle |

## Verification
A snoop write or invalidate presented in one cycle is in the dirty store after the next rising edge. A start pulse puts the block in its busy state one edge later, and after that each band takes one clock. The rectangle for a run therefore rises one edge after the walk visits the first clean band that follows the run, or one edge after it visits the last band. It stays up until the edge where ready is seen high, and `scan_done` rises at the edge after the last rectangle is accepted. The bench drives and samples only on falling edges. It holds ready high and records a rectangle on each falling edge where valid is high, so each accepted rectangle is counted exactly once. Where the stall behaviour is tested, it holds ready low for a fixed number of cycles and checks the held values on every one of them.

// File: rtl/fb_dirty_pkg.sv
package fb_dirty_pkg;

  typedef enum logic [1:0] {
    PLANE_INDEX8  = 2'd0,
    PLANE_COLOR24 = 2'd1,
    PLANE_CONTROL = 2'd2,
    PLANE_NONE    = 2'd3
  } plane_e;

  typedef enum logic [1:0] {
    SCAN_IDLE = 2'd0,
    SCAN_WALK = 2'd1,
    SCAN_EMIT = 2'd2
  } scan_state_e;

endpackage

// File: rtl/snoop_band_decode.sv
module snoop_band_decode #(
  parameter int NUM_BANDS  = 192,
  parameter int BAND_BYTES = 4096,
  parameter int ADDR_W     = 22,
  parameter int BAND_W     = 8
) (
  input  logic              wr_valid,
  input  logic [1:0]        wr_plane,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              band_hit,
  output logic [BAND_W-1:0] band_idx
);
  import fb_dirty_pkg::*;

  localparam int NARROW_SH = $clog2(BAND_BYTES);
  localparam int WIDE_SH   = NARROW_SH + 2;
  localparam int NPLANES   = 3;

  logic [ADDR_W-1:0] cand [NPLANES];
  logic [ADDR_W-1:0] sel_full;
  logic              plane_ok;

  // each plane has its own bytes-per-band; index plane is narrow
  for (genvar p = 0; p < NPLANES; p++) begin : g_plane
    if (p == 0) begin : g_narrow
      assign cand[p] = wr_addr >> NARROW_SH;
    end else begin : g_wide
      assign cand[p] = wr_addr >> WIDE_SH;
    end
  end

  always_comb begin
    sel_full = '0;
    plane_ok = 1'b0;
    case (plane_e'(wr_plane))
      PLANE_INDEX8:  begin sel_full = cand[0]; plane_ok = 1'b1; end
      PLANE_COLOR24: begin sel_full = cand[1]; plane_ok = 1'b1; end
      PLANE_CONTROL: begin sel_full = cand[2]; plane_ok = 1'b1; end
      default:       begin sel_full = '0;      plane_ok = 1'b0; end
    endcase
  end

  assign band_hit = wr_valid && plane_ok && (sel_full < ADDR_W'(NUM_BANDS));
  assign band_idx = sel_full[BAND_W-1:0];

endmodule

// File: rtl/band_dirty_store.sv
module band_dirty_store #(
  parameter int NUM_BANDS = 192,
  parameter int BAND_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [BAND_W-1:0] set_idx,
  input  logic              clr_en,
  input  logic [BAND_W-1:0] clr_idx,
  input  logic              mark_all,
  input  logic [BAND_W-1:0] rd_idx,
  output logic              rd_dirty
);

  logic [NUM_BANDS-1:0] dirty_q, dirty_d;
  logic                 upd_en;

  assign upd_en = set_en | clr_en | mark_all;

  // set beats clear so a write in the visit cycle is not lost
  always_comb begin
    dirty_d = dirty_q;
    if (clr_en)   dirty_d[clr_idx] = 1'b0;
    if (set_en)   dirty_d[set_idx] = 1'b1;
    if (mark_all) dirty_d = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dirty_q <= '0;
    else if (upd_en) dirty_q <= dirty_d;
  end

  assign rd_dirty = dirty_q[rd_idx];

  // R7
  write_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> dirty_q[$past(set_idx)]);

  // R6
  clear_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !mark_all && !(set_en && set_idx == clr_idx)) |=> !dirty_q[$past(clr_idx)]);

  // R8
  mark_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mark_all |=> (&dirty_q));

endmodule

// File: rtl/band_run_scanner.sv
module band_run_scanner #(
  parameter int NUM_BANDS = 192,
  parameter int BAND_ROWS = 4,
  parameter int BAND_W    = 8,
  parameter int ROW_W     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_dirty,
  output logic [BAND_W-1:0] rd_idx,
  output logic              clr_en,
  output logic [BAND_W-1:0] clr_idx,
  output logic              busy,
  output logic              done,
  output logic              rect_valid,
  input  logic              rect_ready,
  output logic [ROW_W-1:0]  rect_row,
  output logic [ROW_W-1:0]  rect_height
);
  import fb_dirty_pkg::*;

  localparam int TOTAL_ROWS = NUM_BANDS * BAND_ROWS;

  scan_state_e       state_q, state_d;
  logic [BAND_W-1:0] idx_q, idx_d;
  logic [BAND_W-1:0] run_q, run_d;
  logic              open_q, open_d;
  logic              fin_q, fin_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic [ROW_W-1:0]  hgt_q, hgt_d;
  logic              done_q, done_d;
  logic              step_en;
  logic              last_band;
  logic [BAND_W-1:0] head_band;
  logic [ROW_W-1:0]  head_rows, here_rows, past_rows, run_rows;

  assign last_band = (idx_q == BAND_W'(NUM_BANDS - 1));
  assign head_band = open_q ? run_q : idx_q;
  assign head_rows = ROW_W'(head_band) * ROW_W'(BAND_ROWS);
  assign run_rows  = ROW_W'(run_q) * ROW_W'(BAND_ROWS);
  assign here_rows = ROW_W'(idx_q) * ROW_W'(BAND_ROWS);
  assign past_rows = (ROW_W'(idx_q) + ROW_W'(1)) * ROW_W'(BAND_ROWS);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    run_d   = run_q;
    open_d  = open_q;
    fin_d   = fin_q;
    row_d   = row_q;
    hgt_d   = hgt_q;
    done_d  = 1'b0;
    clr_en  = 1'b0;
    case (state_q)
      SCAN_IDLE: begin
        if (start) begin
          state_d = SCAN_WALK;
          idx_d   = '0;
          open_d  = 1'b0;
          fin_d   = 1'b0;
        end
      end
      SCAN_WALK: begin
        if (rd_dirty) begin
          clr_en = 1'b1;
          run_d  = head_band;
          open_d = 1'b1;
          if (last_band) begin
            row_d   = head_rows;
            hgt_d   = past_rows - head_rows;
            fin_d   = 1'b1;
            open_d  = 1'b0;
            state_d = SCAN_EMIT;
          end else begin
            idx_d = idx_q + BAND_W'(1);
          end
        end else if (open_q) begin
          row_d   = run_rows;
          hgt_d   = here_rows - run_rows;
          fin_d   = last_band;
          open_d  = 1'b0;
          state_d = SCAN_EMIT;
          if (!last_band) idx_d = idx_q + BAND_W'(1);
        end else if (last_band) begin
          done_d  = 1'b1;
          state_d = SCAN_IDLE;
        end else begin
          idx_d = idx_q + BAND_W'(1);
        end
      end
      SCAN_EMIT: begin
        if (rect_ready) begin
          if (fin_q) begin
            done_d  = 1'b1;
            state_d = SCAN_IDLE;
          end else begin
            state_d = SCAN_WALK;
          end
        end
      end
      default: state_d = SCAN_IDLE;
    endcase
  end

  assign step_en = (state_q != SCAN_IDLE) | start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCAN_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      run_q  <= '0;
      open_q <= 1'b0;
      fin_q  <= 1'b0;
      row_q  <= '0;
      hgt_q  <= '0;
    end else if (step_en) begin
      idx_q  <= idx_d;
      run_q  <= run_d;
      open_q <= open_d;
      fin_q  <= fin_d;
      row_q  <= row_d;
      hgt_q  <= hgt_d;
    end
  end

  assign rd_idx      = idx_q;
  assign clr_idx     = idx_q;
  assign busy        = (state_q != SCAN_IDLE);
  assign done        = done_q;
  assign rect_valid  = (state_q == SCAN_EMIT);
  assign rect_row    = row_q;
  assign rect_height = hgt_q;

  // R9
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rect_valid && !rect_ready) |=> (rect_valid && $stable(rect_row) && $stable(rect_height)));

  // R9
  walk_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rect_valid && !rect_ready) |=> $stable(rd_idx));

  // R4
  rect_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rect_valid |-> (rect_height != '0) &&
      (({1'b0, rect_row} + {1'b0, rect_height}) <= (ROW_W+1)'(TOTAL_ROWS)));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: rtl/fb_band_dirty_tracker.sv
module fb_band_dirty_tracker #(
  parameter int NUM_BANDS  = 192,
  parameter int LINE_BYTES = 1024,
  parameter int BAND_ROWS  = 4,
  parameter int ACTIVE_W   = 1024,
  localparam int BAND_BYTES = LINE_BYTES * BAND_ROWS,
  localparam int ADDR_W     = $clog2(NUM_BANDS * BAND_BYTES * 4),
  localparam int BAND_W     = $clog2(NUM_BANDS),
  localparam int ROW_W      = $clog2(NUM_BANDS * BAND_ROWS + 1),
  localparam int WID_W      = $clog2(ACTIVE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snoop_valid,
  input  logic [1:0]        snoop_plane,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              invalidate,
  input  logic              scan_start,
  output logic              scan_busy,
  output logic              scan_done,
  output logic              rect_valid,
  input  logic              rect_ready,
  output logic [ROW_W-1:0]  rect_row,
  output logic [ROW_W-1:0]  rect_height,
  output logic [WID_W-1:0]  rect_width
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              hit;
  logic [BAND_W-1:0] hit_band;
  logic              clr_en;
  logic [BAND_W-1:0] clr_idx;
  logic [BAND_W-1:0] rd_idx;
  logic              rd_dirty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  snoop_band_decode #(
    .NUM_BANDS (NUM_BANDS),
    .BAND_BYTES(BAND_BYTES),
    .ADDR_W    (ADDR_W),
    .BAND_W    (BAND_W)
  ) u_decode (
    .wr_valid(snoop_valid),
    .wr_plane(snoop_plane),
    .wr_addr (snoop_addr),
    .band_hit(hit),
    .band_idx(hit_band)
  );

  band_dirty_store #(
    .NUM_BANDS(NUM_BANDS),
    .BAND_W   (BAND_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .set_en  (hit),
    .set_idx (hit_band),
    .clr_en  (clr_en),
    .clr_idx (clr_idx),
    .mark_all(invalidate),
    .rd_idx  (rd_idx),
    .rd_dirty(rd_dirty)
  );

  band_run_scanner #(
    .NUM_BANDS(NUM_BANDS),
    .BAND_ROWS(BAND_ROWS),
    .BAND_W   (BAND_W),
    .ROW_W    (ROW_W)
  ) u_scan (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (scan_start),
    .rd_dirty   (rd_dirty),
    .rd_idx     (rd_idx),
    .clr_en     (clr_en),
    .clr_idx    (clr_idx),
    .busy       (scan_busy),
    .done       (scan_done),
    .rect_valid (rect_valid),
    .rect_ready (rect_ready),
    .rect_row   (rect_row),
    .rect_height(rect_height)
  );

  assign rect_width = WID_W'(ACTIVE_W);

endmodule

// File: tb/fb_band_dirty_tracker_test.sv
`timescale 1ns/1ps
module fb_band_dirty_tracker_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        snoop_valid = 1'b0;
  logic [1:0]  snoop_plane = 2'd0;
  logic [21:0] snoop_addr = '0;
  logic        invalidate = 1'b0;
  logic        scan_start = 1'b0;
  logic        rect_ready = 1'b0;
  logic        scan_busy, scan_done, rect_valid;
  logic [9:0]  rect_row, rect_height;
  logic [10:0] rect_width;

  int total = 0;
  int bad = 0;
  int got_n;
  int got_row [0:15];
  int got_h   [0:15];

  always #10 clk = ~clk;

  fb_band_dirty_tracker uut (
    .clk(clk), .rst_n(rst_n),
    .snoop_valid(snoop_valid), .snoop_plane(snoop_plane), .snoop_addr(snoop_addr),
    .invalidate(invalidate), .scan_start(scan_start),
    .scan_busy(scan_busy), .scan_done(scan_done),
    .rect_valid(rect_valid), .rect_ready(rect_ready),
    .rect_row(rect_row), .rect_height(rect_height), .rect_width(rect_width)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic snoop(input int plane, input int addr);
    @(negedge clk);
    snoop_valid = 1'b1;
    snoop_plane = plane[1:0];
    snoop_addr  = addr[21:0];
    @(negedge clk);
    snoop_valid = 1'b0;
  endtask

  task automatic mark_band8(input int band);
    snoop(0, band * 4096 + 100);
  endtask

  // runs (or finishes) a scan with ready high, recording every accepted rectangle
  task automatic collect(input bit do_start);
    bit seen_done = 1'b0;
    got_n = 0;
    if (do_start) begin
      @(negedge clk);
      scan_start = 1'b1;
    end
    rect_ready = 1'b1;
    for (int i = 0; i < 2000 && !seen_done; i++) begin
      @(negedge clk);
      scan_start = 1'b0;
      if (do_start && i == 0) check("R10 busy after start", int'(scan_busy), 1);
      if (rect_valid && got_n < 16) begin
        got_row[got_n] = int'(rect_row);
        got_h[got_n]   = int'(rect_height);
        got_n++;
      end
      if (scan_done) begin
        seen_done = 1'b1;
        check("R10 idle at done", int'(scan_busy), 0);
      end
    end
    check("R10 scan ended", int'(seen_done), 1);
    @(negedge clk);
    check("R10 done one cycle", int'(scan_done), 0);
  endtask

  task automatic t_reset();
    check("R1 valid low", int'(rect_valid), 0);
    check("R1 busy low", int'(scan_busy), 0);
    check("R11 width", int'(rect_width), 1024);
    collect(1'b1);
    check("R1 no rects", got_n, 0);
  endtask

  task automatic t_plane8();
    snoop(0, 3 * 4096 + 17);
    snoop(0, 4095);
    collect(1'b1);
    check("R2 count", got_n, 2);
    check("R2 row0", got_row[0], 0);
    check("R2 h0", got_h[0], 4);
    check("R2 row1", got_row[1], 12);
    check("R2 h1", got_h[1], 4);
  endtask

  task automatic t_wide();
    snoop(1, 7 * 16384 + 5);
    snoop(2, 9 * 16384);
    snoop(3, 0);
    snoop(0, 192 * 4096);
    collect(1'b1);
    check("R3 count", got_n, 2);
    check("R3 row0", got_row[0], 28);
    check("R3 h0", got_h[0], 4);
    check("R3 row1", got_row[1], 36);
    check("R11 width", int'(rect_width), 1024);
  endtask

  task automatic t_merge();
    mark_band8(10); mark_band8(11); mark_band8(12);
    mark_band8(20);
    mark_band8(190); mark_band8(191);
    collect(1'b1);
    check("R4 count", got_n, 3);
    check("R4 row0", got_row[0], 40);
    check("R4 h0", got_h[0], 12);
    check("R4 row1", got_row[1], 80);
    check("R4 h1", got_h[1], 4);
    check("R5 row2", got_row[2], 760);
    check("R5 h2", got_h[2], 8);
    collect(1'b1);
    check("R6 cleared", got_n, 0);
  endtask

  task automatic t_last();
    mark_band8(191);
    collect(1'b1);
    check("R5 count", got_n, 1);
    check("R5 row", got_row[0], 764);
    check("R5 h", got_h[0], 4);
  endtask

  task automatic t_inval();
    @(negedge clk);
    invalidate = 1'b1;
    @(negedge clk);
    invalidate = 1'b0;
    collect(1'b1);
    check("R8 count", got_n, 1);
    check("R8 row", got_row[0], 0);
    check("R8 h", got_h[0], 768);
    collect(1'b1);
    check("R6 after invalidate", got_n, 0);
  endtask

  task automatic t_stall();
    int hold_row;
    int hold_h;
    bit seen = 1'b0;
    mark_band8(5);
    mark_band8(100);
    @(negedge clk);
    rect_ready = 1'b0;
    scan_start = 1'b1;
    @(negedge clk);
    scan_start = 1'b0;
    for (int i = 0; i < 50 && !seen; i++) begin
      if (rect_valid) seen = 1'b1;
      else @(negedge clk);
    end
    check("R9 first rect", int'(seen), 1);
    hold_row = int'(rect_row);
    hold_h   = int'(rect_height);
    check("R9 row", hold_row, 20);
    check("R9 h", hold_h, 4);
    mark_band8(5);
    @(negedge clk);
    scan_start = 1'b1;
    @(negedge clk);
    scan_start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R9 held valid", int'(rect_valid), 1);
      check("R9 held row", int'(rect_row), hold_row);
      check("R9 held h", int'(rect_height), hold_h);
    end
    rect_ready = 1'b1;
    collect(1'b0);
    check("R10 rest count", got_n, 1);
    check("R10 rest row", got_row[0], 400);
    collect(1'b1);
    check("R7 kept count", got_n, 1);
    check("R7 kept row", got_row[0], 20);
    check("R7 kept h", got_h[0], 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_plane8();
    t_wide();
    t_merge();
    t_last();
    t_inval();
    t_stall();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule